// File: doc/BRIEF.md
# Protection-Key Data Access Checker

This block decides, for each memory access, whether a thread may proceed, based on a 4-bit tag carried in the translated page-table entry. The tag selects two control bits in a thread-local 32-bit permission register. One bit blocks every data access and the other blocks data writes only. A thread changes its protection domain by rewriting this register alone; the page tables are never touched.

Each request supplies the key, the access kind and the current execution mode. The response arrives one cycle later and carries an allow/fault flag and a reason code. Key checking applies only to data accesses made in 64-bit mode. Instruction fetches, and every access made in any other mode, always pass. A write port and a read port, each driven like a dedicated instruction, load and return the whole register.

Top module: `pkey_access_checker`

## Requirements
- R1: While reset is high and on the first cycle after it, the permission register reads as zero, so that every key allows every access, and both `rsp_valid` and `reg_rd_valid` are low.
- R2: The register is 32 bits wide. For key k, bit 2k is the access-block bit and bit 2k+1 is the write-block bit. A register write loads all 32 bits at once.
- R3: In 64-bit mode, when the access-block bit of the selected key is set, a data read (kind 00) and a data write (kind 01) both fault with reason 01.
- R4: In 64-bit mode, when only the write-block bit of the selected key is set, a data read passes with reason 00 and a data write faults with reason 10.
- R5: Kind 10 (instruction fetch) and kind 11 (reserved, treated the same way) always pass with reason 00, whatever the register holds.
- R6: Mode is encoded as 00 real, 01 32-bit protected, 10 64-bit, 11 reserved. In every mode except 10, all accesses pass with reason 00.
- R7: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high. The reason is 00 for allowed, 01 for access-blocked and 10 for write-blocked, and never 11. `rsp_fault` is high exactly when the reason is nonzero. Both `rsp_fault` and `rsp_reason` are zero when `rsp_valid` is low.
- R8: A register write applies to requests from the next cycle onward. A request presented in the same cycle as the write is checked against the old value.
- R9: A read strobe returns the full register on `reg_rd_data` in the next cycle, with `reg_rd_valid` high for that one cycle. A read issued in the same cycle as a write returns the old value.
- R10: Only the two bits of the selected key affect a request. Bits that belong to other keys have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request strobe |
| req_key | input | 4 | Protection key from the translated entry |
| req_kind | input | 2 | 00 read, 01 write, 10 fetch, 11 reserved |
| req_mode | input | 2 | 00 real, 01 32-bit, 10 64-bit, 11 reserved |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 32 | New register value |
| reg_rd_en | input | 1 | Register read strobe |
| reg_rd_data | output | 32 | Register value, one cycle after the read strobe |
| reg_rd_valid | output | 1 | Read data valid |
| rsp_valid | output | 1 | Response valid |
| rsp_fault | output | 1 | Access refused |
| rsp_reason | output | 2 | 00 ok, 01 access-blocked, 10 write-blocked |

## Verification
The hardest case to reach from the ports is a write, a read and a request all arriving in the same cycle, with the write changing the very bits the request selects. The request and the read must both see the old value, and the following request must see the new one. Directed sequences place a write next to requests on the affected key and on neighbouring keys. A long random phase then drives write, read and request strobes independently, with mode and kind biased toward 64-bit data accesses. A behavioural model compares every output on every cycle.

// File: rtl/pkey_pkg.sv
package pkey_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_kind_t;

  typedef enum logic [1:0] {
    MODE_REAL   = 2'b00,
    MODE_PROT32 = 2'b01,
    MODE_LONG64 = 2'b10,
    MODE_RSVD   = 2'b11
  } exec_mode_t;

  typedef enum logic [1:0] {
    RSN_OK        = 2'b00,
    RSN_ACCESS_DIS = 2'b01,
    RSN_WRITE_DIS = 2'b10,
    RSN_UNUSED    = 2'b11
  } reason_t;

  localparam int unsigned CTRL_BITS_PER_KEY = 2;

endpackage

// File: rtl/pkey_perm_reg.sv
module pkey_perm_reg #(
  parameter int unsigned REG_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             rd_en,
  output logic [REG_W-1:0] rd_data,
  output logic             rd_valid,
  output logic [REG_W-1:0] perm_q
);

  // State register: the write lands at the edge, so same-cycle users see the old value
  always_ff @(posedge clk) begin
    if (rst) begin
      perm_q <= '0;
    end else if (wr_en) begin
      perm_q <= wr_data;
    end
  end

  // Read port: registered copy of the value held before this edge
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= perm_q;
    end
  end

  // R1: reset clears the register
  p_reset_clear_r1: assert property (@(posedge clk) rst |=> perm_q == '0);

  // R8: a written value is in place one cycle later
  p_write_lands_r8: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> perm_q == $past(wr_data));

  // R9: read data valid follows the strobe by one cycle
  p_read_valid_r9: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  p_read_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);

  // R9: read returns the register as it stood at the strobe
  p_read_old_value_r9: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_data == $past(perm_q));

endmodule

// File: rtl/pkey_field_select.sv
module pkey_field_select #(
  parameter int unsigned NUM_KEYS = 16,
  localparam int unsigned KEY_W   = $clog2(NUM_KEYS),
  localparam int unsigned REG_W   = NUM_KEYS * pkey_pkg::CTRL_BITS_PER_KEY
) (
  input  logic [REG_W-1:0] perm,
  input  logic [KEY_W-1:0] key,
  output logic             blk_access,
  output logic             blk_write
);

  logic [NUM_KEYS-1:0] acc_bits;
  logic [NUM_KEYS-1:0] wr_bits;

  // Split the flat register: even bit blocks all data, odd bit blocks writes
  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
    assign acc_bits[k] = perm[pkey_pkg::CTRL_BITS_PER_KEY*k];
    assign wr_bits[k]  = perm[pkey_pkg::CTRL_BITS_PER_KEY*k + 1];
  end

  always_comb begin
    blk_access = acc_bits[key];
    blk_write  = wr_bits[key];
  end

endmodule

// File: rtl/pkey_verdict.sv
module pkey_verdict
  import pkey_pkg::*;
(
  input  acc_kind_t  kind,
  input  exec_mode_t mode,
  input  logic       blk_access,
  input  logic       blk_write,
  output reason_t    reason
);

  logic data_access;
  logic checking_on;

  always_comb begin
    data_access = (kind == ACC_READ) || (kind == ACC_WRITE);
    checking_on = (mode == MODE_LONG64);
    reason      = RSN_OK;
    if (checking_on && data_access) begin
      if (blk_access) begin
        reason = RSN_ACCESS_DIS;
      end else if (blk_write && kind == ACC_WRITE) begin
        reason = RSN_WRITE_DIS;
      end
    end
  end

endmodule

// File: rtl/pkey_rsp_stage.sv
module pkey_rsp_stage
  import pkey_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  reason_t    in_reason,
  output logic       rsp_valid,
  output logic       rsp_fault,
  output logic [1:0] rsp_reason
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_fault  <= 1'b0;
      rsp_reason <= RSN_OK;
    end else begin
      rsp_valid  <= in_valid;
      rsp_fault  <= in_valid && (in_reason != RSN_OK);
      rsp_reason <= in_valid ? in_reason : RSN_OK;
    end
  end

  // R7: no fault or reason without a response
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> (!rsp_fault && rsp_reason == 2'b00));

  // R7: unused reason code never appears
  p_reason_legal_r7: assert property (@(posedge clk) disable iff (rst)
    rsp_reason != 2'b11);

endmodule

// File: rtl/pkey_access_checker.sv
module pkey_access_checker
  import pkey_pkg::*;
#(
  parameter int unsigned NUM_KEYS = 16,
  localparam int unsigned KEY_W   = $clog2(NUM_KEYS),
  localparam int unsigned REG_W   = NUM_KEYS * CTRL_BITS_PER_KEY
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [KEY_W-1:0] req_key,
  input  logic [1:0]       req_kind,
  input  logic [1:0]       req_mode,
  input  logic             reg_wr_en,
  input  logic [REG_W-1:0] reg_wr_data,
  input  logic             reg_rd_en,
  output logic [REG_W-1:0] reg_rd_data,
  output logic             reg_rd_valid,
  output logic             rsp_valid,
  output logic             rsp_fault,
  output logic [1:0]       rsp_reason
);

  logic [REG_W-1:0] perm_q;
  logic             sel_blk_access;
  logic             sel_blk_write;
  reason_t          verdict;

  pkey_perm_reg #(.REG_W(REG_W)) u_reg (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (reg_wr_en),
    .wr_data  (reg_wr_data),
    .rd_en    (reg_rd_en),
    .rd_data  (reg_rd_data),
    .rd_valid (reg_rd_valid),
    .perm_q   (perm_q)
  );

  pkey_field_select #(.NUM_KEYS(NUM_KEYS)) u_sel (
    .perm       (perm_q),
    .key        (req_key),
    .blk_access (sel_blk_access),
    .blk_write  (sel_blk_write)
  );

  pkey_verdict u_verdict (
    .kind       (acc_kind_t'(req_kind)),
    .mode       (exec_mode_t'(req_mode)),
    .blk_access (sel_blk_access),
    .blk_write  (sel_blk_write),
    .reason     (verdict)
  );

  pkey_rsp_stage u_rsp (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (req_valid),
    .in_reason  (verdict),
    .rsp_valid  (rsp_valid),
    .rsp_fault  (rsp_fault),
    .rsp_reason (rsp_reason)
  );

  // R7: exactly one response per request, one cycle later
  p_resp_follows_req_r7: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  p_no_spurious_resp_r7: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  // R5: fetches and reserved kinds never fault
  p_fetch_passes_r5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind[1]) |=> !rsp_fault);

  // R6: outside 64-bit mode nothing faults
  p_mode_off_passes_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_mode != 2'b10) |=> !rsp_fault);

  // R4: write-block reason only answers a data write
  p_wd_only_on_write_r4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind != 2'b01) |=> rsp_reason != 2'b10);

  // R3: an access-blocked key refuses a data read in 64-bit mode
  p_ad_blocks_read_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == 2'b00 && req_mode == 2'b10 &&
     perm_q[2*req_key]) |=> rsp_reason == 2'b01);

endmodule

// File: tb/tb_pkey_access_checker.sv
`timescale 1ns/1ps
module tb_pkey_access_checker;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [3:0]  req_key = '0;
  logic [1:0]  req_kind = '0;
  logic [1:0]  req_mode = '0;
  logic        reg_wr_en = 1'b0;
  logic [31:0] reg_wr_data = '0;
  logic        reg_rd_en = 1'b0;
  logic [31:0] reg_rd_data;
  logic        reg_rd_valid;
  logic        rsp_valid;
  logic        rsp_fault;
  logic [1:0]  rsp_reason;

  always #2 clk = ~clk;  // 250 MHz

  pkey_access_checker dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_key(req_key), .req_kind(req_kind), .req_mode(req_mode),
    .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data), .reg_rd_en(reg_rd_en),
    .reg_rd_data(reg_rd_data), .reg_rd_valid(reg_rd_valid),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_reason(rsp_reason)
  );

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  // Behavioural reference state
  logic [31:0] m_reg = '0;
  bit          m_written = 1'b0;
  bit          e_rv = 1'b0;
  int          e_reason = 0;
  string       e_tag = "R1";
  bit          e_rdv = 1'b0;
  logic [31:0] e_rd = '0;
  string       e_rdtag = "R1";

  function automatic int ref_reason(logic [31:0] r, int key, int kind, int mode);
    bit a, w;
    a = r[2*key];
    w = r[2*key+1];
    if (mode != 2) return 0;
    if (kind >= 2) return 0;
    if (a) return 1;
    if (w && kind == 1) return 2;
    return 0;
  endfunction

  function automatic string ref_tag(logic [31:0] r, int key, int kind, int mode, bit same_wr);
    if (same_wr) return "R8";
    if (mode != 2) return "R6";
    if (kind >= 2) return "R5";
    if (r[2*key]) return "R3";
    if (r[2*key+1]) return "R4";
    if (r != 0) return "R10";
    return "R7";
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_reg <= '0; m_written <= 1'b0;
      e_rv <= 1'b0; e_reason <= 0; e_tag <= "R1";
      e_rdv <= 1'b0; e_rd <= '0; e_rdtag <= "R1";
    end else begin
      e_rv <= req_valid;
      e_reason <= req_valid ? ref_reason(m_reg, int'(req_key), int'(req_kind), int'(req_mode)) : 0;
      e_tag <= req_valid ? ref_tag(m_reg, int'(req_key), int'(req_kind), int'(req_mode), reg_wr_en) : "R7";
      e_rdv <= reg_rd_en;
      if (reg_rd_en) begin
        e_rd <= m_reg;
        e_rdtag <= reg_wr_en ? "R9" : (m_written ? "R2" : "R1");
      end
      if (reg_wr_en) begin
        m_reg <= reg_wr_data;
        m_written <= 1'b1;
      end
    end
  end

  task automatic cmp(string tag, string what, longint act, longint exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Compare every output every cycle, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      cmp(rst ? "R1" : "R7", "rsp_valid", rsp_valid, e_rv);
      cmp(e_rv ? e_tag : "R7", "rsp_fault", rsp_fault, (e_rv && e_reason != 0));
      cmp(e_rv ? e_tag : "R7", "rsp_reason", rsp_reason, e_rv ? e_reason : 0);
      cmp(rst ? "R1" : "R9", "reg_rd_valid", reg_rd_valid, e_rdv);
      if (e_rdv) cmp(e_rdtag, "reg_rd_data", reg_rd_data, e_rd);
    end
  end

  task automatic step(bit v, int key, int kind, int mode, bit we, logic [31:0] wd, bit re);
    @(negedge clk);
    #0.5;
    req_valid = v; req_key = key[3:0]; req_kind = kind[1:0]; req_mode = mode[1:0];
    reg_wr_en = we; reg_wr_data = wd; reg_rd_en = re;
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 32'h0, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog expired");
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    @(negedge clk); #0.5; rst = 1'b0;
    // R1: reset value read back and all-open checks
    step(0, 0, 0, 0, 0, 32'h0, 1);
    step(1, 7, 1, 2, 0, 32'h0, 0);
    step(1, 15, 0, 2, 0, 32'h0, 0);
    // R8: write access-block on key 3 with a same-cycle request on key 3
    step(1, 3, 0, 2, 1, 32'h0000_0040, 0);
    step(1, 3, 0, 2, 0, 32'h0, 0);   // R3 read faults
    step(1, 3, 1, 2, 0, 32'h0, 1);   // R3 write faults, R2 readback
    step(1, 3, 2, 2, 0, 32'h0, 0);   // R5 fetch passes
    step(1, 3, 1, 1, 0, 32'h0, 0);   // R6 32-bit mode passes
    step(1, 3, 0, 0, 0, 32'h0, 0);   // R6 real mode
    step(1, 3, 1, 3, 0, 32'h0, 0);   // R6 reserved mode
    // R4: write-block only on key 5
    step(1, 5, 0, 2, 1, 32'h0000_0800, 0);
    step(1, 5, 0, 2, 0, 32'h0, 0);
    step(1, 5, 1, 2, 0, 32'h0, 0);
    step(1, 5, 3, 2, 0, 32'h0, 0);   // R5 reserved kind
    // R10: every key blocked but key 9
    step(0, 0, 0, 0, 1, 32'hFFF3_FFFF, 0);
    step(1, 9, 1, 2, 0, 32'h0, 0);
    step(1, 8, 0, 2, 0, 32'h0, 0);
    step(1, 10, 2, 2, 0, 32'h0, 0);
    // R9: read and write in the same cycle returns old value
    step(1, 0, 1, 2, 1, 32'h0000_0002, 1);
    step(1, 0, 1, 2, 0, 32'h0, 1);
    step(1, 0, 0, 2, 0, 32'h0, 0);
    idle();
    // Random phase, biased to 64-bit data accesses
    for (int i = 0; i < 4000; i++) begin
      int kind, mode;
      kind = ($urandom_range(0, 3) == 0) ? int'($urandom_range(2, 3)) : int'($urandom_range(0, 1));
      mode = ($urandom_range(0, 4) == 0) ? int'($urandom_range(0, 3)) : 2;
      step($urandom_range(0, 3) != 0, int'($urandom_range(0, 15)), kind, mode,
           $urandom_range(0, 5) == 0, $urandom, $urandom_range(0, 3) == 0);
    end
    // Mid-run reset: R1 again
    step(0, 0, 0, 0, 1, 32'hFFFF_FFFF, 0);
    @(negedge clk); #0.5; rst = 1'b1;
    reg_wr_en = 1'b0;
    repeat (2) @(negedge clk);
    #0.5; rst = 1'b0;
    step(1, 4, 1, 2, 0, 32'h0, 1);
    idle();
    idle();
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule